// File: doc/BRIEF.md
# Variable-Length ADC Bank Unpacker

This block turns one packed readout bank from a 32-channel front-end board into a stream of per-channel samples. The bank arrives as 32-bit words on a valid/ready input. The first word is a width map, with one bit per channel. Each bit says whether that channel's sample was stored as a compact 4-bit code or as a full 12-bit code. The words that follow carry the samples back to back, and a sample may start in one word and finish in the next.

The unpacker keeps the leftover bits between words in a small bit accumulator. It takes one channel at a time in ascending order and presents each channel as a channel index and a 12-bit value, with a valid strobe and a last flag on the final channel. When the sink stalls, the output holds. When the accumulator already holds enough bits, the input stalls. A bank whose final word arrives too early sets an error flag that stays set until reset.

Top module: `adc_bank_unpacker`

## Requirements
- R1: The first accepted word of a bank is the width map. Bit i = 1 marks channel i as a 12-bit sample and bit i = 0 marks it as a 4-bit sample. Outputs appear in channel order 0 to 31, and `out_chan_o` carries the channel number.
- R2: Samples are packed LSB-first. Each field starts at the lowest unconsumed bit and continues from bit 31 of one word into bit 0 of the next word. A 12-bit sample appears unchanged on `out_value_o`.
- R3: A 4-bit sample is output zero-extended, so bits 11:4 of `out_value_o` are 0.
- R4: A complete bank produces exactly 32 outputs, and `out_last_o` is 1 only with channel 31.
- R5: A bank occupies ceil((4·S + 12·L)/32) payload words, where S and L are the numbers of short and long channels. Padding bits above the last field are discarded, and the next word is taken as a new width map.
- R6: `in_ready_o` is low during decoding whenever the accumulator holds 12 or more unconsumed bits, or holds enough bits for all remaining channels. The accumulator never holds more than 44 bits.
- R7: A word flagged `in_last_i` that arrives before the bank has enough bits, or a width map word flagged `in_last_i`, sets `trunc_err_o`. The flag stays set until reset. The rest of that bank is dropped, `out_last_o` is never raised for it, and the decoder returns to waiting for a width map.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the channel, value and last outputs stay stable. No sample is lost or repeated.
- R9: After reset, `in_ready_o` is 1, `out_valid_o` is 0 and `trunc_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Width map or payload word |
| in_valid_i | input | 1 | Input word valid |
| in_last_i | input | 1 | Input word is the last one of the bank |
| in_ready_o | output | 1 | Input word accepted when high together with valid |
| out_chan_o | output | 5 | Channel index of the current sample |
| out_value_o | output | 12 | Sample value, zero-extended if short |
| out_valid_o | output | 1 | Sample valid |
| out_last_o | output | 1 | Sample is channel 31 |
| out_ready_i | input | 1 | Sink accepts the sample |
| trunc_err_o | output | 1 | Sticky error for a bank that ended too early |

## Verification
Some properties are checked by assertions on every cycle: the accumulator never overflows on a push, a pop never takes more bits than are held, the output holds while stalled, the last flag appears only on channel 31, the remaining-bit budget ends at exactly zero, and the error flag stays sticky. Other behaviour can only be shown by the bench's scenarios. These are the correct bit extraction across word boundaries for mixed width maps, the zero-extension of short codes, the discarding of padding when banks arrive back to back, the input stall under a blocked sink, and the recovery after a truncated bank.

// File: rtl/ubp_pkg.sv
package ubp_pkg;
  localparam int unsigned DEF_NUM_CHAN   = 32;
  localparam int unsigned DEF_WORD_BITS  = 32;
  localparam int unsigned DEF_SHORT_BITS = 4;
  localparam int unsigned DEF_LONG_BITS  = 12;

  typedef enum logic {
    ST_PATTERN = 1'b0,
    ST_PAYLOAD = 1'b1
  } ubp_state_e;
endpackage

// File: rtl/ubp_chan_seq.sv
module ubp_chan_seq #(
  parameter int unsigned NUM_CHAN   = 32,
  parameter int unsigned SHORT_BITS = 4,
  parameter int unsigned LONG_BITS  = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CHAN),
  localparam int unsigned FW_W  = $clog2(LONG_BITS + 1),
  localparam int unsigned REM_W = $clog2(NUM_CHAN * LONG_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [NUM_CHAN-1:0] pattern_i,
  input  logic                adv_i,
  output logic [CH_W-1:0]     chan_o,
  output logic                long_o,
  output logic [FW_W-1:0]     field_w_o,
  output logic [REM_W-1:0]    rem_bits_o,
  output logic                final_o
);
  logic [NUM_CHAN-1:0] pattern_q;
  logic [CH_W-1:0]     chan_q;
  logic [REM_W-1:0]    rem_q;

  function automatic logic [REM_W-1:0] long_count(input logic [NUM_CHAN-1:0] p);
    logic [REM_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_CHAN; i++) n = n + REM_W'(p[i]);
    return n;
  endfunction

  assign chan_o     = chan_q;
  assign long_o     = pattern_q[chan_q];
  assign field_w_o  = long_o ? FW_W'(LONG_BITS) : FW_W'(SHORT_BITS);
  assign rem_bits_o = rem_q;
  assign final_o    = (chan_q == CH_W'(NUM_CHAN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pattern_q <= '0;
      chan_q    <= '0;
      rem_q     <= '0;
    end else if (load_i) begin
      pattern_q <= pattern_i;
      chan_q    <= '0;
      rem_q     <= REM_W'(NUM_CHAN * SHORT_BITS)
                 + long_count(pattern_i) * REM_W'(LONG_BITS - SHORT_BITS);
    end else if (adv_i) begin
      chan_q <= chan_q + CH_W'(1);
      rem_q  <= rem_q - REM_W'(field_w_o);
    end
  end

  AST_REM_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rem_q >= REM_W'(field_w_o)); // R4
  AST_FINAL_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && final_o |-> rem_q == REM_W'(field_w_o)); // R5
endmodule

// File: rtl/ubp_bit_acc.sv
module ubp_bit_acc #(
  parameter int unsigned WORD_BITS = 32,
  parameter int unsigned LONG_BITS = 12,
  localparam int unsigned ACC_W = WORD_BITS + LONG_BITS,
  localparam int unsigned CNT_W = $clog2(ACC_W + 1),
  localparam int unsigned FW_W  = $clog2(LONG_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 push_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 pop_i,
  input  logic [FW_W-1:0]      pop_w_i,
  output logic [LONG_BITS-1:0] head_o,
  output logic [CNT_W-1:0]     cnt_o
);
  logic [ACC_W-1:0] acc_q, acc_sh, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_sh, cnt_d;

  // bits above cnt_q are always zero, so a push can OR in place
  always_comb begin
    acc_sh = acc_q;
    cnt_sh = cnt_q;
    if (pop_i) begin
      acc_sh = acc_q >> pop_w_i;
      cnt_sh = cnt_q - CNT_W'(pop_w_i);
    end
    acc_d = acc_sh;
    cnt_d = cnt_sh;
    if (push_i) begin
      acc_d = acc_sh | (ACC_W'(word_i) << cnt_sh);
      cnt_d = cnt_sh + CNT_W'(WORD_BITS);
    end
    if (clear_i) begin
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o = acc_q[LONG_BITS-1:0];
  assign cnt_o  = cnt_q;

  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNT_W'(LONG_BITS)); // R6
  AST_POP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q >= CNT_W'(pop_w_i)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= ACC_W); // R6
endmodule

// File: rtl/ubp_out_stage.sv
module ubp_out_stage #(
  parameter int unsigned CH_W      = 5,
  parameter int unsigned LONG_BITS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CH_W-1:0]      chan_i,
  input  logic [LONG_BITS-1:0] value_i,
  input  logic                 last_i,
  input  logic                 ready_i,
  output logic                 free_o,
  output logic                 valid_o,
  output logic [CH_W-1:0]      chan_o,
  output logic [LONG_BITS-1:0] value_o,
  output logic                 last_o
);
  assign free_o = ~valid_o | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      chan_o  <= '0;
      value_o <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      chan_o  <= chan_i;
      value_o <= value_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(chan_o) && $stable(value_o) && $stable(last_o)); // R8
  AST_LOAD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o || ready_i); // R8
endmodule

// File: rtl/adc_bank_unpacker.sv
module adc_bank_unpacker
  import ubp_pkg::*;
#(
  parameter int unsigned NUM_CHAN   = DEF_NUM_CHAN,
  parameter int unsigned WORD_BITS  = DEF_WORD_BITS,
  parameter int unsigned SHORT_BITS = DEF_SHORT_BITS,
  parameter int unsigned LONG_BITS  = DEF_LONG_BITS,
  localparam int unsigned CH_W  = $clog2(NUM_CHAN),
  localparam int unsigned FW_W  = $clog2(LONG_BITS + 1),
  localparam int unsigned REM_W = $clog2(NUM_CHAN * LONG_BITS + 1),
  localparam int unsigned CNT_W = $clog2(WORD_BITS + LONG_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WORD_BITS-1:0] in_data_i,
  input  logic                 in_valid_i,
  input  logic                 in_last_i,
  output logic                 in_ready_o,
  output logic [CH_W-1:0]      out_chan_o,
  output logic [LONG_BITS-1:0] out_value_o,
  output logic                 out_valid_o,
  output logic                 out_last_o,
  input  logic                 out_ready_i,
  output logic                 trunc_err_o
);
  ubp_state_e state_q;
  logic last_seen_q, err_q;

  logic [CH_W-1:0]      seq_chan;
  logic                 seq_long, seq_final;
  logic [FW_W-1:0]      seq_fw;
  logic [REM_W-1:0]     seq_rem;
  logic [LONG_BITS-1:0] acc_head;
  logic [CNT_W-1:0]     acc_cnt;
  logic                 out_free;

  logic pat_fire, word_fire, need_more, starved, have_field, emit, acc_clear;
  logic [LONG_BITS-1:0] field_val;

  assign need_more  = 32'(acc_cnt) < 32'(seq_rem);
  assign have_field = 32'(acc_cnt) >= 32'(seq_fw);
  assign starved    = (state_q == ST_PAYLOAD) & last_seen_q & need_more;

  assign in_ready_o = (state_q == ST_PATTERN)
                    | ((state_q == ST_PAYLOAD) & ~last_seen_q & need_more
                       & (32'(acc_cnt) < LONG_BITS));

  assign pat_fire  = (state_q == ST_PATTERN) & in_valid_i & in_ready_o;
  assign word_fire = (state_q == ST_PAYLOAD) & in_valid_i & in_ready_o;
  assign emit      = (state_q == ST_PAYLOAD) & ~starved & have_field & out_free;
  assign acc_clear = pat_fire | starved | (emit & seq_final);

  assign field_val = seq_long ? acc_head : LONG_BITS'(acc_head[SHORT_BITS-1:0]);

  ubp_chan_seq #(
    .NUM_CHAN(NUM_CHAN), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)
  ) i_seq (
    .clk_i, .rst_ni,
    .load_i    (pat_fire & ~in_last_i),
    .pattern_i (in_data_i[NUM_CHAN-1:0]),
    .adv_i     (emit),
    .chan_o    (seq_chan),
    .long_o    (seq_long),
    .field_w_o (seq_fw),
    .rem_bits_o(seq_rem),
    .final_o   (seq_final)
  );

  ubp_bit_acc #(
    .WORD_BITS(WORD_BITS), .LONG_BITS(LONG_BITS)
  ) i_acc (
    .clk_i, .rst_ni,
    .clear_i(acc_clear),
    .push_i (word_fire),
    .word_i (in_data_i),
    .pop_i  (emit),
    .pop_w_i(seq_fw),
    .head_o (acc_head),
    .cnt_o  (acc_cnt)
  );

  ubp_out_stage #(
    .CH_W(CH_W), .LONG_BITS(LONG_BITS)
  ) i_out (
    .clk_i, .rst_ni,
    .load_i (emit),
    .chan_i (seq_chan),
    .value_i(field_val),
    .last_i (seq_final),
    .ready_i(out_ready_i),
    .free_o (out_free),
    .valid_o(out_valid_o),
    .chan_o (out_chan_o),
    .value_o(out_value_o),
    .last_o (out_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PATTERN;
      last_seen_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if ((pat_fire & in_last_i) | starved) err_q <= 1'b1;
      case (state_q)
        ST_PATTERN: if (pat_fire & ~in_last_i) begin
          state_q     <= ST_PAYLOAD;
          last_seen_q <= 1'b0;
        end
        ST_PAYLOAD: begin
          if (word_fire & in_last_i) last_seen_q <= 1'b1;
          if (starved | (emit & seq_final)) begin
            state_q     <= ST_PATTERN;
            last_seen_q <= 1'b0;
          end
        end
        default: state_q <= ST_PATTERN;
      endcase
    end
  end

  assign trunc_err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_err_o |=> trunc_err_o); // R7
  AST_LAST_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_chan_o == CH_W'(NUM_CHAN - 1)); // R4
  AST_NO_READY_ON_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_fire && in_last_i |=> !in_ready_o); // R7
endmodule

// File: tb/test_adc_bank_unpacker.sv
module test_adc_bank_unpacker;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [4:0]  out_chan;
  logic [11:0] out_value;
  logic        out_valid, out_last;
  logic        out_ready = 1'b1;
  logic        trunc_err;

  always #2.5 clk = ~clk;

  adc_bank_unpacker i_adc_bank_unpacker (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_chan_o(out_chan), .out_value_o(out_value), .out_valid_o(out_valid),
    .out_last_o(out_last), .out_ready_i(out_ready), .trunc_err_o(trunc_err)
  );

  typedef struct packed { logic [4:0] ch; logic [11:0] v; logic lng; } exp_t;
  typedef struct packed { logic [31:0] pat; logic [7:0] seed; logic stall; } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 8'd1, 1'b0},
    '{32'hFFFF_FFFF, 8'd2, 1'b1},
    '{32'h8000_0001, 8'd3, 1'b0},
    '{32'h1234_5678, 8'd4, 1'b1},
    '{32'hAAAA_AAAA, 8'd5, 1'b0},
    '{32'h0F0F_00F1, 8'd6, 1'b1}
  };

  exp_t        exp_q[$];
  logic [31:0] bw [12];
  int n_checks = 0, n_fail = 0, got_last = 0;
  logic stall_mode = 1'b0, hold_out = 1'b0, done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic make_bank(input logic [31:0] pat, input int seed, output int nw);
    logic [383:0] bits;
    int pos;
    exp_t e;
    bits = '1;  // padding left as ones
    pos = 0;
    for (int ch = 0; ch < 32; ch++) begin
      logic [11:0] v;
      int w;
      w = pat[ch] ? 12 : 4;
      v = pat[ch] ? 12'((ch * 149 + seed * 23 + 7) % 4096) : 12'((ch * 3 + seed) % 16);
      for (int b = 0; b < w; b++) begin
        bits[pos] = v[b];
        pos++;
      end
      e.ch = 5'(ch); e.v = v; e.lng = pat[ch];
      exp_q.push_back(e);
    end
    nw = (pos + 31) / 32;
    for (int k = 0; k < 12; k++) bw[k] = bits[k*32 +: 32];
  endtask

  task automatic send_word(input logic [31:0] w, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_last = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic in_idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_bank(input logic [31:0] pat, input int first, input int n_send, input bit mark_last);
    if (first == 0) send_word(pat, 1'b0);
    for (int k = first; k < n_send; k++) send_word(bw[k], mark_last && (k == n_send - 1));
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // output collector
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = hold_out ? 1'b0 : (stall_mode ? lfsr[0] : 1'b1);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected output", 32'(out_chan), 32'hFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_chan == e.ch, "R1 channel order", 32'(out_chan), 32'(e.ch));
          if (e.lng) check(out_value == e.v, "R2 long value", 32'(out_value), 32'(e.v));
          else       check(out_value == e.v, "R3 short zero-extended", 32'(out_value), 32'(e.v));
          check(out_last == (e.ch == 5'd31), "R4 last flag", 32'(out_last), 32'(e.ch == 5'd31));
        end
        if (out_last) got_last++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int nw, last0;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R9 ready after reset", 32'(in_ready), 1);
    check(out_valid == 1'b0, "R9 no output after reset", 32'(out_valid), 0);
    check(trunc_err == 1'b0, "R9 error clear after reset", 32'(trunc_err), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: banks back to back, padding filled with ones (R5)
    for (int i = 0; i < 6; i++) begin
      stall_mode = VECS[i].stall;
      make_bank(VECS[i].pat, int'(VECS[i].seed), nw);
      send_bank(VECS[i].pat, 0, nw, 1'b1);
    end
    in_idle();
    wait_drain();
    stall_mode = 1'b0;
    check(exp_q.size() == 0, "R5 all banks drained", exp_q.size(), 0);
    check(got_last == 6, "R4 one last per bank", got_last, 6);
    check(trunc_err == 1'b0, "R7 no error on well formed banks", 32'(trunc_err), 0);

    // R6/R8: blocked sink stalls input and holds output
    hold_out = 1'b1;
    make_bank(32'hFFFF_FFFF, 9, nw);
    send_word(32'hFFFF_FFFF, 1'b0);
    send_word(bw[0], 1'b0);
    fork
      send_bank(32'hFFFF_FFFF, 1, nw, 1'b1);
      begin
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R6 input stalled with bits held", 32'(in_ready), 0);
        check(out_valid == 1'b1, "R8 output held valid", 32'(out_valid), 1);
        check(out_chan == 5'd0, "R8 channel held", 32'(out_chan), 0);
        repeat (3) @(negedge clk);
        #1;
        check(out_chan == 5'd0 && out_valid, "R8 no advance while stalled", 32'(out_chan), 0);
        hold_out = 1'b0;
      end
    join
    in_idle();
    wait_drain();
    check(exp_q.size() == 0, "R8 all samples delivered once", exp_q.size(), 0);

    // R7: bank ends after two of four words
    last0 = got_last;
    make_bank(32'h0000_0000, 11, nw);
    send_bank(32'h0000_0000, 0, 2, 1'b1);
    in_idle();
    repeat (20) @(negedge clk);
    #1;
    check(trunc_err == 1'b1, "R7 truncation flagged", 32'(trunc_err), 1);
    check(got_last == last0, "R7 no last on truncated bank", got_last, last0);
    check(in_ready == 1'b1, "R7 back to waiting", 32'(in_ready), 1);
    exp_q.delete();

    // R7: width map flagged last
    send_word(32'h0000_0003, 1'b1);
    in_idle();
    repeat (4) @(negedge clk);
    #1;
    check(trunc_err == 1'b1, "R7 error sticky", 32'(trunc_err), 1);
    check(in_ready == 1'b1, "R7 still waiting for width map", 32'(in_ready), 1);

    // good bank after errors
    make_bank(32'h5500_00FF, 13, nw);
    send_bank(32'h5500_00FF, 0, nw, 1'b1);
    in_idle();
    wait_drain();
    check(exp_q.size() == 0, "R7 decode resumes after error", exp_q.size(), 0);
    check(got_last == last0 + 1, "R4 last after recovery", got_last, last0 + 1);
    check(trunc_err == 1'b1, "R7 error held until reset", 32'(trunc_err), 1);

    // reset clears the error
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(trunc_err == 1'b0, "R9 reset clears error", 32'(trunc_err), 0);
    check(out_valid == 1'b0, "R9 reset clears output", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R9 ready in reset", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule